// File: doc/BRIEF.md
# Credit-Flow Pipelined Link

This block joins a producer and a consumer across a link whose forward data path and backward credit path each pass through a parameterised number of register stages. The sending end keeps a count of free places in the receiving buffer. It accepts a word from its source port only while that count is non-zero, or when a credit is coming back in that same cycle. Each accepted word costs one credit. The word then travels down the forward delay line into a receive FIFO. Each time the consumer takes a word from that FIFO, one credit pulse travels back up the backward delay line and adds to the count.

The count is loaded during reset from a run-time credit cap, clamped to the FIFO depth. A smaller cap lets fewer words be in flight, so it lowers the link rate. The credit loop takes FWD_STAGES + BWD_STAGES + 1 cycles, where the extra cycle is the registered FIFO output. The steady rate is therefore C / (FWD_STAGES + BWD_STAGES + 1) words per cycle, limited to one. With the defaults, a cap of 1, 2 or 3 gives one third, two thirds or full rate.

The sender is controlled by a two-state machine. In `CR_OPEN` the count is non-zero and the source is always ready. In `CR_DRAINED` the count is zero and the source is ready only while a credit is returning. The machine moves from `CR_OPEN` to `CR_DRAINED` (transition "exhaust") when the next count is zero. It moves from `CR_DRAINED` to `CR_OPEN` (transition "replenish") when the next count is non-zero. In every other case it stays in its state. Reset enters `CR_OPEN` if the clamped cap is non-zero and `CR_DRAINED` otherwise.

Top module: `credit_link`

## Requirements
- R1: At reset release, snk_valid and rx_overflow are 0. The credit count equals min(cfg_credit_limit, RX_DEPTH) as sampled in the last reset cycle, so src_ready is 1 exactly when that value is non-zero.
- R2: A word is accepted (src_valid and src_ready both 1) only when the count is non-zero or a credit returns in that cycle. Each acceptance removes one credit. With the sink stalled, exactly C words are accepted.
- R3: A credit returns BWD_STAGES cycles after a sink handshake. A returning credit and an acceptance in the same cycle leave the count unchanged, so a credit arriving at a count of zero is spent in that same cycle.
- R4: With an empty FIFO, a word accepted in cycle t is offered on the sink port in cycle t + FWD_STAGES + 1.
- R5: Words leave the sink port unchanged and in the order they were accepted, under any pattern of source and sink stalls.
- R6: With the source always valid and the sink always ready, the steady rate is min(1, C/(FWD_STAGES+BWD_STAGES+1)). With the defaults this is 10, 20 and 30 words per 30 cycles for C = 1, 2 and 3.
- R7: Once C words are outstanding and the sink is stalled, src_ready stays 0 until the sink consumes a word.
- R8: A cap above RX_DEPTH is clamped to RX_DEPTH. A cap of 0 never lets a word through. Changing the cap outside reset has no effect on the link rate.
- R9: rx_overflow is sticky. It is set by a word that arrives while the FIFO is full and not being read, and it stays 0 under credit flow control.
- R10: While snk_valid is 1 and snk_ready is 0, snk_valid stays 1 and snk_data is stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the credit cap is loaded while it is low |
| cfg_credit_limit | input | $clog2(RX_DEPTH+1) | Credit cap, used only during reset |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Sender can accept a word this cycle |
| src_data | input | DATA_W | Source word |
| snk_valid | output | 1 | Receive FIFO holds a word |
| snk_ready | input | 1 | Consumer takes the word this cycle |
| snk_data | output | DATA_W | Head word of the receive FIFO |
| rx_overflow | output | 1 | Sticky flag: a word arrived at a full FIFO |

## Verification
The bound checker tests the following on every cycle:
- the credit arithmetic: decrement on a send, increment on a return, no change when both happen together;
- that no word is accepted without a credit;
- the reset load and the clamp;
- the absence of FIFO overflow;
- that the sink word is held while the sink is stalled.

Some behaviour can only be shown by the bench scenarios, because it emerges from the whole loop rather than from one cycle: the end-to-end latency, the rate under each cap, the ordering and integrity of the data, and the fact that a cap change outside reset has no effect.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;

    typedef enum logic [0:0] {
        CR_DRAINED = 1'b0,
        CR_OPEN    = 1'b1
    } cr_state_e;

endpackage

// File: rtl/link_delay.sv
module link_delay #(
    parameter int W      = 1,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                logic [W-1:0] q;
                if (s == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (!rst_n) q <= '0;
                        else        q <= din;
                    end
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (!rst_n) q <= '0;
                        else        q <= g_stage[s-1].q;
                    end
                end
            end
            assign dout = g_stage[STAGES-1].q;
        end
    endgenerate

endmodule

// File: rtl/credit_tx.sv
module credit_tx
    import credit_link_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             src_valid,
    input  logic             credit_ret,
    output logic             src_ready,
    output logic             fire,
    output logic [CNT_W-1:0] credit_cnt
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(RX_DEPTH);

    cr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    assign load_val = (cfg_limit > DEPTH_C) ? DEPTH_C : cfg_limit;

    // State register: loads the clamped cap throughout reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= load_val;
            state_q <= (load_val != '0) ? CR_OPEN : CR_DRAINED;
        end else begin
            cnt_q   <= cnt_d;
            state_q <= state_d;
        end
    end

    // Outputs and next state
    always_comb begin
        src_ready = 1'b0;
        unique case (state_q)
            CR_OPEN:    src_ready = 1'b1;
            CR_DRAINED: src_ready = credit_ret;
            default:    src_ready = 1'b0;
        endcase
        fire = src_valid && src_ready;
        unique case ({credit_ret, fire})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
        state_d = (cnt_d != '0) ? CR_OPEN : CR_DRAINED;
    end

    assign credit_cnt = cnt_q;

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         pop,
    output logic         overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             full, push;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full     = (fill == CNT_W'(DEPTH));
    assign rd_valid = (fill != '0);
    assign rd_data  = mem[rd_ptr];
    assign pop      = rd_valid && rd_ready;
    assign push     = wr_valid && (!full || pop);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            if (wr_valid && full && !pop) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int DATA_W     = 8,
    parameter int FWD_STAGES = 1,
    parameter int BWD_STAGES = 1,
    parameter int RX_DEPTH   = 4,
    localparam int CNT_W     = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_credit_limit,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [DATA_W-1:0] snk_data,
    output logic              rx_overflow
);

    localparam int LNK_W = DATA_W + 1;

    logic             tx_fire;
    logic [CNT_W-1:0] credit_cnt;
    logic             credit_ret;
    logic             credit_pulse;
    logic [LNK_W-1:0] link_out;

    credit_tx #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_limit  (cfg_credit_limit),
        .src_valid  (src_valid),
        .credit_ret (credit_ret),
        .src_ready  (src_ready),
        .fire       (tx_fire),
        .credit_cnt (credit_cnt)
    );

    link_delay #(.W(LNK_W), .STAGES(FWD_STAGES)) u_fwd (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({tx_fire, src_data}),
        .dout (link_out)
    );

    rx_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (link_out[LNK_W-1]),
        .wr_data  (link_out[DATA_W-1:0]),
        .rd_ready (snk_ready),
        .rd_valid (snk_valid),
        .rd_data  (snk_data),
        .pop      (credit_pulse),
        .overflow (rx_overflow)
    );

    link_delay #(.W(1), .STAGES(BWD_STAGES)) u_bwd (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (credit_pulse),
        .dout (credit_ret)
    );

endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_credit_limit,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic [DATA_W-1:0] snk_data,
    input logic              rx_overflow,
    input logic              tx_fire,
    input logic              credit_ret,
    input logic [CNT_W-1:0]  credit_cnt
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(RX_DEPTH);

    function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v);
        return (v > DEPTH_C) ? DEPTH_C : v;
    endfunction

    // R1: the count after reset comes from the clamped cap
    p_reset_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> credit_cnt == clamp($past(cfg_credit_limit)));

    // R2: no send without a credit in hand or arriving
    p_send_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> (credit_cnt != '0 || credit_ret));

    // R2: a send alone removes one credit
    p_send_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire && !credit_ret |=> credit_cnt == CNT_W'($past(credit_cnt) - 1'b1));

    // R3: a return alone adds one credit
    p_ret_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fire && credit_ret |=> credit_cnt == CNT_W'($past(credit_cnt) + 1'b1));

    // R3: a send and a return together leave the count unchanged
    p_reuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire && credit_ret |=> credit_cnt == $past(credit_cnt));

    // R8: the count never exceeds the buffer depth
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        credit_cnt <= DEPTH_C);

    // R9: lossless operation
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_overflow);

    // R10: the sink word is held while the sink is stalled
    p_sink_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid && !snk_ready |=> snk_valid && $stable(snk_data));

endmodule

bind credit_link credit_link_chk #(
    .DATA_W  (DATA_W),
    .RX_DEPTH(RX_DEPTH),
    .CNT_W   (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_credit_limit(cfg_credit_limit),
    .snk_valid       (snk_valid),
    .snk_ready       (snk_ready),
    .snk_data        (snk_data),
    .rx_overflow     (rx_overflow),
    .tx_fire         (tx_fire),
    .credit_ret      (credit_ret),
    .credit_cnt      (credit_cnt)
);

// File: tb/test_credit_link.sv
module test_credit_link;

    localparam int DATA_W = 8;
    localparam int FWD    = 1;
    localparam int BWD    = 1;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_credit_limit = '0;
    logic              src_valid = 1'b0;
    logic              src_ready;
    logic [DATA_W-1:0] src_data = '0;
    logic              snk_valid;
    logic              snk_ready = 1'b0;
    logic [DATA_W-1:0] snk_data;
    logic              rx_overflow;

    logic [DATA_W-1:0] sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   fires    = 0;
    int   takes    = 0;
    logic [DATA_W-1:0] seq = '0;
    bit   src_en = 0, src_rand = 0, snk_en = 0, snk_rand = 0;

    always #10 clk = ~clk;

    credit_link #(
        .DATA_W(DATA_W), .FWD_STAGES(FWD), .BWD_STAGES(BWD), .RX_DEPTH(DEPTH)
    ) i_credit_link (
        .clk(clk), .rst_n(rst_n), .cfg_credit_limit(cfg_credit_limit),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
        .rx_overflow(rx_overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Driver: applies inputs just after each rising edge
    initial forever begin
        @(posedge clk);
        #1;
        src_data  = seq;
        src_valid = src_en && (!src_rand || ($urandom_range(0, 1) == 1));
        snk_ready = snk_en && (!snk_rand || ($urandom_range(0, 2) != 0));
    end

    // Monitor and scoreboard: samples at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (src_valid && src_ready) begin
                sb_q.push_back(src_data);
                fires++;
                seq++;
            end
            if (snk_valid && snk_ready) begin
                takes++;
                if (sb_q.size() == 0) check("R5 unexpected word", 1, 0);
                else check("R5 data order", int'(snk_data), int'(sb_q.pop_front()));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int lim);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_credit_limit = CNT_W'(lim);
        src_en = 0; snk_en = 0; src_rand = 0; snk_rand = 0;
        wait_n(3);
        rst_n = 1'b1;
        sb_q.delete();
    endtask

    task automatic rate(input int lim, input int exp, input bit change_cap, input string req);
        int t0;
        do_reset(lim);
        src_en = 1; snk_en = 1;
        wait_n(12);
        if (change_cap) cfg_credit_limit = CNT_W'(1);
        t0 = takes;
        wait_n(30);
        check(req, takes - t0, exp);
        src_en = 0;
        wait_n(10);
    endtask

    task automatic stall(input int lim, input int exp);
        int f0;
        do_reset(lim);
        f0 = fires;
        src_en = 1;
        wait_n(20);
        check("R2/R7 words accepted while sink stalled", fires - f0, exp);
        check("R7 src_ready low when credits spent", int'(src_ready), 0);
        if (exp > 0) begin
            check("R10 sink valid held", int'(snk_valid), 1);
            check("R10 sink data is head word", int'(snk_data), int'(sb_q[0]));
        end
        src_en = 0;
        snk_en = 1;
        wait_n(20);
        check("R5 all words delivered", sb_q.size(), 0);
        check("R9 no overflow", int'(rx_overflow), 0);
    endtask

    initial begin
        // R1: reset state
        do_reset(3);
        check("R1 src_ready after reset", int'(src_ready), 1);
        check("R1 snk_valid after reset", int'(snk_valid), 0);
        check("R1 rx_overflow after reset", int'(rx_overflow), 0);

        // R4: latency of a single word through an empty link
        src_en = 1;
        wait_n(1);
        check("R4 word accepted", int'(src_valid && src_ready), 1);
        src_en = 0;
        wait_n(1);
        check("R4 not yet at sink", int'(snk_valid), 0);
        wait_n(1);
        check("R4 at sink after FWD+1", int'(snk_valid), 1);
        snk_en = 1;
        wait_n(5);
        check("R4 delivered", sb_q.size(), 0);

        // R1 with a zero cap, R8
        do_reset(0);
        check("R1/R8 zero cap not ready", int'(src_ready), 0);

        // R6 and R3: rate per cap
        rate(1, 10, 0, "R6/R3 rate with one credit");
        rate(2, 20, 0, "R6 rate with two credits");
        rate(3, 30, 0, "R6/R3 full rate with three credits");
        rate(4, 30, 0, "R6 full rate with four credits");
        rate(3, 30, 1, "R8 cap change outside reset ignored");

        // R2, R7, R8, R10: stalled sink
        stall(2, 2);
        stall(7, 4);
        stall(0, 0);

        // R5, R9: random traffic
        for (int lim = 1; lim <= 4; lim++) begin
            do_reset(lim);
            src_en = 1; src_rand = 1; snk_en = 1; snk_rand = 1;
            wait_n(400);
            src_en = 0; snk_rand = 0;
            wait_n(30);
            check("R5 random traffic drained", sb_q.size(), 0);
            check("R9 random traffic no overflow", int'(rx_overflow), 0);
        end

        summary();
        $finish;
    end

endmodule